// File: doc/BRIEF.md
# Dual-Mode Burst Address Generator

This block holds the address of a four-beat burst and produces the address of each beat. An external address is registered when either of two active-low address strobes is asserted. One strobe is meant for a processor and is honoured only while the active-low chip enable is low. The other strobe is meant for a controller and does not depend on the chip enable. After a load, each clock edge with the active-low advance input asserted moves a 2-bit beat counter forward. The low two address bits are derived from the start offset and that counter.

A static order select input picks how the low bits move. When it is high, the order is interleaved: the low bits are the start bits XOR the beat index. When it is low, the order is linear: the low bits count up from the start and wrap modulo four. The bits above the low two always come unchanged from the registered address. The block drives the full beat address and a flag that is set once a burst has been loaded. Memory access and write control belong to other blocks.

Top module: `burst_addr_gen`

## Requirements
- R1: After synchronous reset, `cur_addr` is all zeros and `burst_active` is 0.
- R2: When `ctrl_strobe_n` is low at a rising edge, `cur_addr` equals the `ext_addr` sampled at that edge from the next cycle on, the beat index restarts at 0, and `burst_active` becomes 1.
- R3: `proc_strobe_n` low loads `ext_addr` only when `chip_en_n` is also low at that edge. When `chip_en_n` is high and `ctrl_strobe_n` is high, `proc_strobe_n` low leaves `cur_addr` unchanged.
- R4: A strobe at the same edge as an asserted `advance_n` wins: the new address is loaded at beat 0 and no step is taken.
- R5: With `order_sel` = 1 (interleaved), beat k of a burst has `cur_addr[1:0]` = start[1:0] XOR k.
- R6: With `order_sel` = 0 (linear), beat k of a burst has `cur_addr[1:0]` = (start[1:0] + k) mod 4.
- R7: An edge with `advance_n` high and no strobe that takes effect leaves `cur_addr` unchanged (a wait cycle).
- R8: Advances past the fourth beat keep wrapping inside the same aligned group of four. Beat 4 equals beat 0, and beat 5 equals beat 1.
- R9: Stepping never changes `cur_addr` above bit 1. Those bits always equal the loaded address.
- R10: Before the first load after reset, `advance_n` low has no effect: `cur_addr` stays zero and `burst_active` stays 0.
- R11: When both strobes are low in the same cycle with `chip_en_n` low, the processor strobe takes priority and `ext_addr` is loaded at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W | External first address of a burst |
| proc_strobe_n | input | 1 | Processor address strobe, active low, gated by chip_en_n |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| chip_en_n | input | 1 | Chip enable, active low, qualifies proc_strobe_n |
| advance_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Static order select: 1 interleaved, 0 linear |
| cur_addr | output | ADDR_W | Current beat address |
| burst_active | output | 1 | Set once a burst has been loaded |

## Verification
Some rules are checked by assertions on every cycle. These are: a load captures the external address, an ungated processor strobe is ignored, a wait cycle holds the address, the upper bits are never changed by stepping, the counter steps by exactly one, and the counter stays idle before the first load. Only the bench scenarios can show the actual beat orders. These are the interleaved and linear sequences for all four start offsets with wait cycles between beats, the wrap after the fourth beat, and the result of a strobe that arrives together with advance or together with the other strobe.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic  active;
        beat_t beat;
    } burst_state_t;

    // Maps the beat index onto the low address bits for the selected order.
    function automatic beat_t map_beat(order_e ord, beat_t start, beat_t idx);
        beat_t r;
        if (ord == ORD_INTERLEAVE) r = start ^ idx;
        else                       r = start + idx;
        return r;
    endfunction

endpackage

// File: rtl/strobe_decode.sv
module strobe_decode (
    input  logic proc_strobe_n,
    input  logic ctrl_strobe_n,
    input  logic chip_en_n,
    output logic load,
    output logic load_from_proc
);
    logic proc_hit;
    logic ctrl_hit;

    always_comb begin
        proc_hit       = !proc_strobe_n && !chip_en_n;
        ctrl_hit       = !ctrl_strobe_n;
        // The processor strobe has priority; both sources load the same address.
        load_from_proc = proc_hit;
        load           = proc_hit || ctrl_hit;
    end
endmodule

// File: rtl/addr_hold.sv
module addr_hold #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] base_addr
);
    always_ff @(posedge clk) begin
        if (rst)       base_addr <= '0;
        else if (load) base_addr <= ext_addr;
    end

    AST_BASE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        load |=> base_addr == $past(ext_addr)); // R2
    AST_BASE_KEPT: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(base_addr)); // R9
endmodule

// File: rtl/burst_counter.sv
module burst_counter
    import burst_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         advance_n,
    output burst_state_t st
);
    burst_state_t nxt;

    always_comb begin
        nxt = st;
        if (load) begin
            nxt.active = 1'b1;
            nxt.beat   = '0;
        end else if (st.active && !advance_n) begin
            nxt.beat = st.beat + beat_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance_n && st.active) |=> st.beat == $past(st.beat) + beat_t'(1)); // R8
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        load |=> (st.beat == '0) && st.active); // R4
    AST_IDLE_ADV: assert property (@(posedge clk) disable iff (rst)
        (!load && !st.active) |=> !st.active && $stable(st.beat)); // R10
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              chip_en_n,
    input  logic              advance_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              burst_active
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic              load;
    logic              load_from_proc;
    logic [ADDR_W-1:0] base_addr;
    burst_state_t      st;
    beat_t             low_bits;

    strobe_decode u_dec (
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .chip_en_n     (chip_en_n),
        .load          (load),
        .load_from_proc(load_from_proc)
    );

    addr_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .ext_addr (ext_addr),
        .base_addr(base_addr)
    );

    burst_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .advance_n(advance_n),
        .st       (st)
    );

    always_comb begin
        low_bits     = map_beat(order_e'(order_sel), base_addr[BEAT_W-1:0], st.beat);
        cur_addr     = {base_addr[ADDR_W-1:BEAT_W], low_bits};
        burst_active = st.active;
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_strobe_n || load_from_proc) |=> cur_addr == $past(ext_addr)); // R2
    AST_PROC_GATED: assert property (@(posedge clk) disable iff (rst)
        (!proc_strobe_n && chip_en_n && ctrl_strobe_n && advance_n)
        |=> (cur_addr == $past(cur_addr)) || (order_sel != $past(order_sel))); // R3
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (proc_strobe_n && ctrl_strobe_n && advance_n)
        |=> (cur_addr == $past(cur_addr)) || (order_sel != $past(order_sel))); // R7
    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        !load |=> cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W])); // R9
    AST_PROC_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (!proc_strobe_n && !ctrl_strobe_n && !chip_en_n) |-> load_from_proc); // R11
    initial begin
        AST_WIDTH_OK: assert (UPPER_W > 0); // R9
    end
endmodule

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
    localparam int W = 17;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] ext_addr = '0;
    logic         proc_strobe_n = 1'b1;
    logic         ctrl_strobe_n = 1'b1;
    logic         chip_en_n = 1'b1;
    logic         advance_n = 1'b1;
    logic         order_sel = 1'b1;
    logic [W-1:0] cur_addr;
    logic         burst_active;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(W)) uut (
        .clk(clk), .rst(rst), .ext_addr(ext_addr),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .chip_en_n(chip_en_n), .advance_n(advance_n), .order_sel(order_sel),
        .cur_addr(cur_addr), .burst_active(burst_active)
    );

    // {order_sel, start[1:0], beat3, beat2, beat1, beat0}
    localparam logic [10:0] VEC [0:7] = '{
        {1'b1, 2'd0, 8'b11100100},
        {1'b1, 2'd1, 8'b10110001},
        {1'b1, 2'd2, 8'b01001110},
        {1'b1, 2'd3, 8'b00011011},
        {1'b0, 2'd0, 8'b11100100},
        {1'b0, 2'd1, 8'b00111001},
        {1'b0, 2'd2, 8'b01001110},
        {1'b0, 2'd3, 8'b10010011}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [W-1:0] exp_addr, logic exp_act);
        tests++;
        if (cur_addr !== exp_addr || burst_active !== exp_act) begin
            fails++;
            $display("FAIL %s: got addr %h act %b, expected addr %h act %b",
                     req, cur_addr, burst_active, exp_addr, exp_act);
        end
    endtask

    task automatic idle();
        proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; advance_n = 1'b1; chip_en_n = 1'b1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] a;
        tick(); tick();
        rst = 1'b0;
        chk("R1 reset", '0, 1'b0);

        // R10: advance before any load
        advance_n = 1'b0; tick(); tick();
        chk("R10 advance before load", '0, 1'b0);
        idle();

        // Table walk: R5 R6 R7 R8 R9
        for (int i = 0; i < 8; i++) begin
            logic [W-1:0] upper_part;
            upper_part = W'((32'h1a5 + i * 32'h333) << 2);
            a = upper_part | W'(VEC[i][9:8]);
            order_sel = VEC[i][10];
            ext_addr  = a;
            if (i % 2 == 0) ctrl_strobe_n = 1'b0;
            else begin proc_strobe_n = 1'b0; chip_en_n = 1'b0; end
            tick(); idle(); ext_addr = ~a;
            chk("R2 load", a, 1'b1);
            for (int k = 1; k <= 5; k++) begin
                logic [W-1:0] e;
                e = upper_part | W'(VEC[i][2*(k%4) +: 2]);
                advance_n = 1'b0; tick(); advance_n = 1'b1;
                chk(VEC[i][10] ? (k >= 4 ? "R8 wrap" : "R5 interleaved")
                               : (k >= 4 ? "R8 wrap" : "R6 linear"), e, 1'b1);
                tick();
                chk("R7 wait R9 upper", e, 1'b1);
            end
        end

        // R3: processor strobe ignored while chip enable is high
        order_sel = 1'b0;
        ext_addr = 17'h0abc4; ctrl_strobe_n = 1'b0; tick(); idle();
        chk("R2 reload", 17'h0abc4, 1'b1);
        ext_addr = 17'h15553; proc_strobe_n = 1'b0; chip_en_n = 1'b1; tick(); idle();
        chk("R3 gated proc strobe", 17'h0abc4, 1'b1);
        proc_strobe_n = 1'b0; chip_en_n = 1'b0; tick(); idle();
        chk("R3 enabled proc strobe", 17'h15553, 1'b1);

        // R4: strobe together with advance loads beat 0
        advance_n = 1'b0; tick();
        chk("R6 linear step", 17'h15550, 1'b1);
        ext_addr = 17'h00022; ctrl_strobe_n = 1'b0; advance_n = 1'b0; tick(); idle();
        chk("R4 strobe beats advance", 17'h00022, 1'b1);

        // R11: both strobes together
        ext_addr = 17'h1fff1; proc_strobe_n = 1'b0; ctrl_strobe_n = 1'b0; chip_en_n = 1'b0;
        tick(); idle();
        chk("R11 both strobes", 17'h1fff1, 1'b1);
        order_sel = 1'b1; advance_n = 1'b0; tick(); idle();
        chk("R5 interleaved step", 17'h1fff0, 1'b1);

        // R1: reset again mid-burst
        rst = 1'b1; tick(); rst = 1'b0;
        chk("R1 reset mid-burst", '0, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule